// File: doc/BRIEF.md
# Multi-Mode Symbol Boundary Aligner

This block sits behind a deserializer that delivers 10-bit parallel words whose boundaries are arbitrary with respect to the line symbols. It keeps the previous input word, forms a 20-bit window with the current one, and compares every candidate boundary (offsets 0 to 9) against an alignment pattern in the same cycle. The chosen candidate is registered and presented as the aligned output word, together with a flag that marks when that word equals the active pattern.

Three behaviours are selected at run time. In manual mode a rising edge on the align request arms a one-shot search; the first matching boundary found is kept until the next request. In slip mode each rising edge of the slip request moves the boundary by one bit. In automatic mode the block looks for the 8B/10B comma itself, acquires lock after a run of commas at one boundary, and drops lock only after code errors outweigh good words.

Top module: `word_aligner`

## Requirements
- R1: After a synchronous active-low reset, aligned_word is 0, pattern_det is 0, synced is 0, the boundary offset is 0 and no search is armed.
- R2: Bits are MSB-first in time. With P the previous input word and C the current one, the candidate at offset k is bits (19-k) down to (10-k) of {P, C}; aligned_word shows, one clock later, the candidate at the offset that is in force after that cycle's update.
- R3: With the short-length setting (cfg_len7 = 1) only bits 9:3 of a candidate are compared with bits 9:3 of the pattern; otherwise all 10 bits are compared.
- R4: Mode value 0 (and the unused value 3) is manual: a rising edge of align_req starts a search that keeps running each cycle until a candidate matches; the lowest matching offset is taken at once and then held, unchanged by later data, until the next rising edge.
- R5: Mode value 1 is slip: each rising edge of slip_req advances the offset by exactly one, from 9 back to 0; a held high level causes one step only, and slip_req has no effect in the other modes.
- R6: pattern_det is high for exactly those output cycles in which aligned_word matches the active pattern at the active length.
- R7: Mode value 2 is automatic: the pattern is fixed to the 7-bit comma prefixes 0011111 and 1100000 (both running disparities), cfg_pattern and cfg_len7 are ignored, and while not synced the offset follows the lowest offset holding a comma.
- R8: In automatic mode synced rises after commas are found at the same offset on 3 consecutive cycles; while synced the offset does not move.
- R9: While synced, a word at the locked offset whose count of ones is outside 4 to 6 is a code error; each run of 4 good words cancels one pending error, and the 4th pending error clears synced.
- R10: synced is 0 in the cycle after any cycle whose mode is not automatic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_word | input | 10 | Unaligned deserialized word, earliest bit in bit 9 |
| mode | input | 2 | 0 manual, 1 slip, 2 automatic, 3 as manual |
| cfg_pattern | input | 10 | Alignment pattern for manual and slip modes |
| cfg_len7 | input | 1 | 1 compares only the top 7 pattern bits |
| align_req | input | 1 | Rising edge arms a manual search |
| slip_req | input | 1 | Rising edge moves the boundary one bit in slip mode |
| aligned_word | output | 10 | Word at the selected boundary, registered |
| pattern_det | output | 1 | Output word matches the active pattern |
| synced | output | 1 | Automatic-mode lock indication |

## Verification
The embedded properties watch, on every cycle, that the offset stays in range, that one slip edge moves it by exactly one with wrap, that an idle manual aligner and a locked automatic aligner never move the boundary, that lock is only gained on a comma at the held offset, and that lock is only lost after a code error or a mode change. Whether the lowest matching boundary is the one picked, whether the short compare ignores the low bits, the exact count of commas needed to lock and the balance of errors against good words are shown only by the bench's reference model and its directed sequences at several bit phases.

// File: rtl/wa_pkg.sv
// Shared constants and mode encoding for the word aligner.
// Assumes a 10-bit symbol datapath carrying 8B/10B code groups.
package wa_pkg;
    typedef enum logic [1:0] {
        MODE_MANUAL = 2'd0,
        MODE_SLIP   = 2'd1,
        MODE_AUTO   = 2'd2,
        MODE_SPARE  = 2'd3
    } wa_mode_e;

    // Comma code group for both running disparities, earliest bit in bit 9.
    localparam logic [9:0] COMMA_NEG = 10'b0011111010;
    localparam logic [9:0] COMMA_POS = 10'b1100000101;
endpackage

// File: rtl/wa_window.sv
// Holds the previous input word and exposes every candidate boundary
// of the two-word window. Assumes the earliest received bit is the MSB.
module wa_window #(
    parameter int W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        rx_word,
    output logic [W-1:0][W-1:0] cand
);
    logic [W-1:0]   prev_q;
    logic [2*W-1:0] win;

    // Keep the last word so a boundary may straddle two inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= rx_word;
    end

    assign win = {prev_q, rx_word};

    // One slice per offset: offset k starts k bits into the older word.
    for (genvar k = 0; k < W; k++) begin : g_cand
        assign cand[k] = win[2*W-1-k -: W];
    end
endmodule

// File: rtl/wa_matcher.sv
// Compares every candidate against two patterns at full or short length.
// Assumes the short compare keeps the SHORT_LEN most significant bits.
module wa_matcher #(
    parameter int W         = 10,
    parameter int SHORT_LEN = 7
) (
    input  logic [W-1:0][W-1:0] cand,
    input  logic [W-1:0]        pat_a,
    input  logic [W-1:0]        pat_b,
    input  logic                len_short,
    output logic [W-1:0]        hit
);
    localparam logic [W-1:0] SHORT_MASK = {{SHORT_LEN{1'b1}}, {(W-SHORT_LEN){1'b0}}};

    logic [W-1:0] mask;
    assign mask = len_short ? SHORT_MASK : '1;

    // Parallel compare at every offset against either pattern.
    for (genvar k = 0; k < W; k++) begin : g_cmp
        assign hit[k] = (((cand[k] ^ pat_a) & mask) == '0) ||
                        (((cand[k] ^ pat_b) & mask) == '0);
    end
endmodule

// File: rtl/wa_sync_fsm.sv
// Lock acquisition and loss tracking for automatic mode.
// Assumes ACQ_N >= 2 and that inputs describe the current cycle's window.
module wa_sync_fsm #(
    parameter int ACQ_N     = 3,
    parameter int LOSS_N    = 4,
    parameter int FORGIVE_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic comma_found,
    input  logic same_off,
    input  logic word_err,
    output logic sync
);
    localparam int AW = $clog2(ACQ_N + 1);
    localparam int EW = $clog2(LOSS_N + 1);
    localparam int GW = $clog2(FORGIVE_N + 1);

    logic [AW-1:0] acq_q;
    logic [EW-1:0] err_q;
    logic [GW-1:0] good_q;
    logic          sync_q;

    // Count commas while hunting, then balance errors against good words.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            acq_q  <= '0;
            err_q  <= '0;
            good_q <= '0;
            sync_q <= 1'b0;
        end else if (!sync_q) begin
            if (comma_found) begin
                if (acq_q != '0 && same_off) begin
                    if (acq_q == AW'(ACQ_N - 1)) begin
                        sync_q <= 1'b1;
                        acq_q  <= '0;
                        err_q  <= '0;
                        good_q <= '0;
                    end else begin
                        acq_q <= acq_q + AW'(1);
                    end
                end else begin
                    acq_q <= AW'(1);
                end
            end else begin
                acq_q <= '0;
            end
        end else if (word_err) begin
            good_q <= '0;
            if (err_q == EW'(LOSS_N - 1)) begin
                sync_q <= 1'b0;
                err_q  <= '0;
                acq_q  <= '0;
            end else begin
                err_q <= err_q + EW'(1);
            end
        end else if (err_q != '0) begin
            if (good_q == GW'(FORGIVE_N - 1)) begin
                err_q  <= err_q - EW'(1);
                good_q <= '0;
            end else begin
                good_q <= good_q + GW'(1);
            end
        end
    end

    assign sync = sync_q;

    AST_ERR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        err_q < EW'(LOSS_N)); // R9
    AST_SYNC_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_q) |-> $past(comma_found && same_off && en)); // R8
    AST_SYNC_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_q) |-> ($past(word_err) || !$past(en))); // R9
endmodule

// File: rtl/word_aligner.sv
// Top of the aligner: boundary selection for manual, slip and automatic
// modes, and the registered output stage. Assumes W = 10 for the comma.
module word_aligner
    import wa_pkg::*;
#(
    parameter int W         = 10,
    parameter int SHORT_LEN = 7,
    parameter int ACQ_N     = 3,
    parameter int LOSS_N    = 4,
    parameter int FORGIVE_N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rx_word,
    input  logic [1:0]   mode,
    input  logic [W-1:0] cfg_pattern,
    input  logic         cfg_len7,
    input  logic         align_req,
    input  logic         slip_req,
    output logic [W-1:0] aligned_word,
    output logic         pattern_det,
    output logic         synced
);
    localparam int OW = $clog2(W);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0][W-1:0] cand;
    logic [W-1:0]        hit;
    logic [W-1:0]        pat_a, pat_b;
    logic                len_s, is_auto, is_slip, is_man;
    logic                req_q, slip_q, req_rise, slip_rise;
    logic                armed_q, armed_nxt;
    logic [OW-1:0]       off_q, off_nxt, first_hit;
    logic                any_hit, same_off, word_err, sync_w;
    logic [CW-1:0]       ones;

    assign is_auto = (mode == MODE_AUTO);
    assign is_slip = (mode == MODE_SLIP);
    assign is_man  = !is_auto && !is_slip;

    assign pat_a = is_auto ? COMMA_NEG : cfg_pattern;
    assign pat_b = is_auto ? COMMA_POS : cfg_pattern;
    assign len_s = is_auto ? 1'b1 : cfg_len7;

    wa_window #(.W(W)) u_win (
        .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .cand(cand)
    );

    wa_matcher #(.W(W), .SHORT_LEN(SHORT_LEN)) u_match (
        .cand(cand), .pat_a(pat_a), .pat_b(pat_b), .len_short(len_s), .hit(hit)
    );

    // Lowest matching offset wins.
    always_comb begin
        first_hit = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (hit[k]) first_hit = OW'(k);
        end
    end

    assign any_hit  = |hit;
    assign same_off = (first_hit == off_q);

    // Ones count of the word at the held boundary, for code error checks.
    always_comb begin
        ones = '0;
        for (int k = 0; k < W; k++) ones = ones + CW'(cand[off_q][k]);
    end

    assign word_err = (ones < CW'(W/2 - 1)) || (ones > CW'(W/2 + 1));

    // Request edge detectors so a held level acts once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            slip_q <= 1'b0;
        end else begin
            req_q  <= align_req;
            slip_q <= slip_req;
        end
    end

    assign req_rise  = align_req && !req_q;
    assign slip_rise = slip_req && !slip_q;

    wa_sync_fsm #(.ACQ_N(ACQ_N), .LOSS_N(LOSS_N), .FORGIVE_N(FORGIVE_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .en(is_auto), .comma_found(any_hit),
        .same_off(same_off), .word_err(word_err), .sync(sync_w)
    );

    // Next boundary offset and manual search arming per mode.
    always_comb begin
        off_nxt   = off_q;
        armed_nxt = armed_q;
        if (is_man) begin
            if (armed_q || req_rise) begin
                if (any_hit) begin
                    off_nxt   = first_hit;
                    armed_nxt = 1'b0;
                end else begin
                    armed_nxt = 1'b1;
                end
            end
        end else if (is_slip) begin
            armed_nxt = 1'b0;
            if (slip_rise) off_nxt = (off_q == OW'(W-1)) ? '0 : off_q + OW'(1);
        end else begin
            armed_nxt = 1'b0;
            if (!sync_w && any_hit) off_nxt = first_hit;
        end
    end

    // Boundary state and registered output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q        <= '0;
            armed_q      <= 1'b0;
            aligned_word <= '0;
            pattern_det  <= 1'b0;
        end else begin
            off_q        <= off_nxt;
            armed_q      <= armed_nxt;
            aligned_word <= cand[off_nxt];
            pattern_det  <= hit[off_nxt];
        end
    end

    assign synced = sync_w;

    AST_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        off_q < OW'(W)); // R5
    AST_SLIP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_slip && slip_rise) |=>
        off_q == (($past(off_q) == OW'(W-1)) ? OW'(0) : $past(off_q) + OW'(1))); // R5
    AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_man && !armed_q && !req_rise) |=> $stable(off_q)); // R4
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_auto && sync_w) |=> $stable(off_q)); // R8
    AST_SYNC_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !is_auto |=> !synced); // R10
endmodule

// File: tb/sim_word_aligner.sv
`timescale 1ns/1ps
module sim_word_aligner;
    localparam logic [9:0] CN   = 10'b0011111010;
    localparam logic [9:0] CP   = 10'b1100000101;
    localparam logic [9:0] DAT  = 10'b1010101010;
    localparam logic [9:0] BAD  = 10'h3ff;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] rx_word = '0;
    logic [1:0] mode = 2'd0;
    logic [9:0] cfg_pattern = '0;
    logic       cfg_len7 = 1'b0;
    logic       align_req = 1'b0;
    logic       slip_req = 1'b0;
    logic [9:0] aligned_word;
    logic       pattern_det;
    logic       synced;

    int checks = 0;
    int failures = 0;

    // reference state
    logic [9:0] m_prev = '0;
    int         m_off = 0;
    logic       m_armed = 0, m_req_q = 0, m_slip_q = 0, m_sync = 0;
    int         m_acq = 0, m_err = 0, m_good = 0;
    logic [9:0] exp_word = '0;
    logic       exp_det = 0;

    // stream generator state
    int         s_phase = 0;
    logic [9:0] s_last = '0;

    always #2 clk = ~clk;

    word_aligner u0 (
        .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .mode(mode),
        .cfg_pattern(cfg_pattern), .cfg_len7(cfg_len7), .align_req(align_req),
        .slip_req(slip_req), .aligned_word(aligned_word),
        .pattern_det(pattern_det), .synced(synced)
    );

    function automatic logic [9:0] cand_of(logic [9:0] p, logic [9:0] c, int k);
        logic [19:0] w;
        w = {p, c};
        return 10'(w >> (10 - k));
    endfunction

    function automatic logic match_of(logic [9:0] c, logic [9:0] pat, logic l7);
        logic [9:0] mk;
        mk = l7 ? 10'b1111111000 : 10'h3ff;
        return ((c ^ pat) & mk) == 10'd0;
    endfunction

    function automatic logic ones_bad(logic [9:0] c);
        int n;
        n = $countones(c);
        return (n < 4) || (n > 6);
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, expv, $time);
        end
    endtask

    // Reference step from the requirements, applied for the coming edge.
    task automatic model_step();
        logic [9:0] cd [10];
        logic [9:0] hv;
        logic [9:0] pa, pb;
        logic l7, auto_m, slip_m, man_m, rr, sr, any, werr;
        int first, off_n;
        auto_m = (mode == 2'd2);
        slip_m = (mode == 2'd1);
        man_m  = !auto_m && !slip_m;
        pa = auto_m ? CN : cfg_pattern;
        pb = auto_m ? CP : cfg_pattern;
        l7 = auto_m ? 1'b1 : cfg_len7;
        first = 0;
        for (int k = 0; k < 10; k++) begin
            cd[k] = cand_of(m_prev, rx_word, k);
            hv[k] = match_of(cd[k], pa, l7) || match_of(cd[k], pb, l7);
        end
        for (int k = 9; k >= 0; k--) if (hv[k]) first = k;
        any  = |hv;
        rr   = align_req && !m_req_q;
        sr   = slip_req && !m_slip_q;
        werr = ones_bad(cd[m_off]);
        off_n = m_off;
        if (man_m) begin
            if (m_armed || rr) begin
                if (any) begin off_n = first; m_armed = 0; end
                else m_armed = 1;
            end
        end else if (slip_m) begin
            m_armed = 0;
            if (sr) off_n = (m_off == 9) ? 0 : m_off + 1;
        end else begin
            m_armed = 0;
            if (!m_sync && any) off_n = first;
        end
        if (!auto_m) begin
            m_acq = 0; m_err = 0; m_good = 0; m_sync = 0;
        end else if (!m_sync) begin
            if (any) begin
                if (m_acq != 0 && first == m_off) begin
                    if (m_acq == 2) begin m_sync = 1; m_acq = 0; m_err = 0; m_good = 0; end
                    else m_acq++;
                end else m_acq = 1;
            end else m_acq = 0;
        end else if (werr) begin
            m_good = 0;
            if (m_err == 3) begin m_sync = 0; m_err = 0; m_acq = 0; end
            else m_err++;
        end else if (m_err != 0) begin
            if (m_good == 3) begin m_err--; m_good = 0; end
            else m_good++;
        end
        exp_word = cd[off_n];
        exp_det  = hv[off_n];
        m_off    = off_n;
        m_req_q  = align_req;
        m_slip_q = slip_req;
        m_prev   = rx_word;
    endtask

    // Drive one word, advance one clock, compare against the model.
    task automatic drive(input logic [9:0] w);
        @(negedge clk);
        rx_word = w;
        model_step();
        @(posedge clk);
        #1;
        chk(aligned_word == exp_word, "R2 aligned word", aligned_word, exp_word);
        chk(pattern_det == exp_det, "R6 pattern flag", pattern_det, exp_det);
        chk(synced == m_sync, "R8 sync flag", synced, m_sync);
    endtask

    // Send one line symbol at the current bit phase.
    task automatic send(input logic [9:0] sym);
        logic [19:0] pr;
        pr = {s_last, sym};
        s_last = sym;
        drive(10'(pr >> s_phase));
    endtask

    initial begin
        #700000;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        chk(aligned_word == 10'd0, "R1 reset word", aligned_word, 0);
        chk(pattern_det == 1'b0, "R1 reset flag", pattern_det, 0);
        chk(synced == 1'b0, "R1 reset sync", synced, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 manual one-shot search, 10-bit pattern, phase 4
        mode = 2'd0; cfg_pattern = CN; cfg_len7 = 0; s_phase = 4;
        send(DAT); send(DAT); send(DAT);
        align_req = 1; send(DAT); align_req = 0;
        send(DAT); send(CN); send(DAT);
        chk(pattern_det == 1'b1, "R4 manual lock flag", pattern_det, 1);
        chk(aligned_word == CN, "R4 manual lock word", aligned_word, CN);
        // R4 phase change without request: boundary held
        s_phase = 7;
        send(DAT); send(CN); send(DAT);
        chk(pattern_det == 1'b0, "R4 hold without request", pattern_det, 0);
        align_req = 1; send(DAT); align_req = 0;
        send(CN); send(DAT);
        chk(pattern_det == 1'b1, "R4 relock after request", pattern_det, 1);

        // R3 short compare ignores low three bits
        cfg_len7 = 1; cfg_pattern = {CN[9:3], 3'b101};
        align_req = 1; send(DAT); align_req = 0;
        send(CN); send(DAT);
        chk(pattern_det == 1'b1, "R3 short match flag", pattern_det, 1);
        chk(aligned_word == CN, "R3 short match word", aligned_word, CN);
        cfg_len7 = 0;
        send(CN); send(DAT);
        chk(pattern_det == 1'b0, "R3 full length rejects", pattern_det, 0);

        // R5 slip: lock at phase 3 on a comma stream, then slip
        cfg_pattern = CN; s_phase = 3;
        align_req = 1; send(CN); align_req = 0;
        send(CN); send(CN);
        mode = 2'd1; send(CN);
        chk(pattern_det == 1'b1, "R5 slip start aligned", pattern_det, 1);
        slip_req = 1;
        for (int i = 0; i < 5; i++) begin
            send(CN);
            chk(pattern_det == 1'b0, "R5 held level one step", pattern_det, 0);
        end
        slip_req = 0; send(CN);
        for (int i = 0; i < 9; i++) begin
            slip_req = 1; send(CN); slip_req = 0; send(CN);
        end
        chk(pattern_det == 1'b1, "R5 ten steps wrap back", pattern_det, 1);

        // R7 R8 automatic acquisition, config ignored, phase 6
        mode = 2'd2; cfg_pattern = 10'h155; cfg_len7 = 0; s_phase = 6;
        send(DAT); send(DAT); send(DAT);
        send(CN); send(CN); send(CN);
        chk(synced == 1'b0, "R8 not yet synced", synced, 0);
        send(CN);
        chk(synced == 1'b1, "R8 synced after three", synced, 1);
        chk(aligned_word == CN, "R7 comma found", aligned_word, CN);

        // R9 error balance
        send(BAD); send(BAD); send(BAD);
        send(DAT); send(DAT); send(DAT); send(DAT);
        send(BAD); send(DAT);
        chk(synced == 1'b1, "R9 forgiven error keeps sync", synced, 1);
        send(BAD); send(DAT);
        chk(synced == 1'b0, "R9 fourth error drops sync", synced, 0);
        send(CN); send(CN); send(CN); send(CN);
        chk(synced == 1'b1, "R8 reacquire", synced, 1);

        // R10 leaving automatic mode clears sync
        mode = 2'd0; send(CN);
        chk(synced == 1'b0, "R10 sync cleared off auto", synced, 0);

        // Random mix against the reference model (R2 R6 R8 R9)
        for (int seg = 0; seg < 60; seg++) begin
            mode = 2'($urandom_range(0, 3));
            cfg_len7 = 1'($urandom_range(0, 1));
            cfg_pattern = ($urandom_range(0, 1) != 0) ? CN : CP;
            s_phase = $urandom_range(0, 9);
            for (int i = 0; i < 40; i++) begin
                logic [9:0] sym;
                int pick;
                pick = $urandom_range(0, 9);
                sym = (pick < 3) ? CN : (pick < 5) ? CP : (pick < 9) ? DAT : 10'($urandom());
                align_req = ($urandom_range(0, 15) == 0);
                slip_req  = ($urandom_range(0, 3) == 0);
                send(sym);
            end
        end
        align_req = 0; slip_req = 0;

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule